// File: doc/BRIEF.md
# Completion Interrupt Aggregator

This block collects per-descriptor completion events from three transfer categories (isochronous, interrupt and asynchronous) and folds them into one level-type host interrupt line. Every category owns 32 descriptor slots. A completion sets the slot's bit in that category's done map. Each category also has an OR mask and an AND mask that decide whether a completion should raise the category's bit in a shared status register. The OR mask fires on any listed descriptor. The AND mask fires only once every listed descriptor has completed.

Software reads and writes the block through a simple synchronous register port. Reading a done map returns it and clears it. Status bits are cleared by writing ones to them. A per-category enable register decides which status bits drive the interrupt pin. The scheduler that produces completions sits outside the block and drives one event strobe and one slot number per category.

Top module: `cmpl_irq_hub`

## Requirements
- R1: After a synchronous active-low reset, all done maps, masks, status bits and enable bits are zero, `irq` is low, and every register address reads 0.
- R2: A completion strobe for category c and slot s sets bit s of done map c at the next clock edge. Earlier bits are kept until the map is read.
- R3: Reading a done map returns its current value in the same cycle and clears it at the next edge. A completion for that category arriving in the same cycle as the read is kept in the cleared map.
- R4: A completion sets status bit c at the next edge when the updated done map ANDed with the OR mask of c is nonzero. Bit 0 is isochronous, bit 1 is interrupt and bit 2 is asynchronous.
- R5: A completion sets status bit c at the next edge when the AND mask of c is nonzero and every bit of it is set in the updated done map. An AND mask of zero never triggers.
- R6: A completion that meets neither the OR rule nor the AND rule leaves the status register unchanged, and so does a cycle with no completion and no status write.
- R7: Writing the status register clears each bit written as 1 and leaves each bit written as 0. A status bit set in the same cycle as its clear stays set.
- R8: `irq` is high exactly when some status bit and its enable bit are both set. A completion in a disabled category still sets its status bit without raising `irq`.
- R9: `irq` is level type. It stays high until every status bit whose enable is set has been cleared.
- R10: Register map: address {c,00} is done map c (read clears), {c,01} is the OR mask of c, {c,10} is the AND mask of c, for c = 0..2. Address 1100 is status and 1101 is enable (bits 2:0). Masks and enable read back as written, and every other address reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_valid | input | 3 | Completion strobe, one bit per category |
| evt_slot | input | 15 | Completed slot number, 5 bits per category, category c at [5c+4:5c] |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears a done map when it selects one) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the current address |
| irq | output | 1 | Level interrupt to the host |

## Verification
A wrong done map shows up one cycle later in two ways: an OR or AND condition that fires when it should not, or fails to fire when it should, and a wrong value returned by the next done-map read. A status bit left set or wrongly cleared changes `irq` combinationally from the following edge, and a status read shows it in that same cycle. The cases that need care are the cycles where a read-clear or a write-one-clear coincides with a new completion. There, a wrong priority is visible only on the very next read, so the bench samples right after that edge.

// File: rtl/cmpl_irq_pkg.sv
// Package: shared sizes and register address encoding for the completion
// interrupt aggregator. Assumes at most three categories so that the
// control group fits in the fourth address group.
package cmpl_irq_pkg;
    localparam int CI_NUM_CAT  = 3;
    localparam int CI_NUM_SLOT = 32;
    localparam int CI_ADDR_W   = 4;
    localparam int CI_DATA_W   = 32;

    // Low address bits select a register inside a category group.
    typedef enum logic [1:0] {
        FLD_DONE = 2'd0,
        FLD_OR   = 2'd1,
        FLD_AND  = 2'd2,
        FLD_RSVD = 2'd3
    } cat_field_e;

    // High address bits equal to this pick the control group.
    localparam logic [1:0] GRP_CTRL   = 2'd3;
    localparam logic [1:0] CTRL_STAT  = 2'd0;
    localparam logic [1:0] CTRL_ENA   = 2'd1;
endpackage

// File: rtl/cmpl_mask_eval.sv
// Module: combinational evaluation of the OR and AND mask rules for one
// category. Assumes the done map given is the value after this cycle's
// update, so a completion can satisfy the rule in the cycle it arrives.
module cmpl_mask_eval #(
    parameter int NUM_SLOT = 32
) (
    input  logic [NUM_SLOT-1:0] done_map,
    input  logic [NUM_SLOT-1:0] or_mask,
    input  logic [NUM_SLOT-1:0] and_mask,
    output logic                or_hit,
    output logic                and_hit
);
    // Any masked slot done, or all slots of a non-empty AND set done.
    always_comb begin
        or_hit  = |(done_map & or_mask);
        and_hit = (|and_mask) && ((done_map & and_mask) == and_mask);
    end
endmodule

// File: rtl/cmpl_cat_unit.sv
// Module: per-category state, holding the done map, OR mask and AND mask,
// plus the fire strobe that sets the category's status bit. Assumes at most
// one completion per category per cycle. A read-clear and a completion in
// the same cycle keep the completion.
module cmpl_cat_unit #(
    parameter int NUM_SLOT = 32,
    localparam int SLOT_W = $clog2(NUM_SLOT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                evt_valid,
    input  logic [SLOT_W-1:0]   evt_slot,
    input  logic                wr_or,
    input  logic                wr_and,
    input  logic                rd_done,
    input  logic [NUM_SLOT-1:0] wdata,
    output logic [NUM_SLOT-1:0] done_map,
    output logic [NUM_SLOT-1:0] or_mask,
    output logic [NUM_SLOT-1:0] and_mask,
    output logic                fire
);
    logic [NUM_SLOT-1:0] evt_bit;
    logic [NUM_SLOT-1:0] done_next;
    logic                or_hit;
    logic                and_hit;

    // One-hot vector of the slot completing this cycle.
    always_comb begin
        evt_bit = '0;
        if (evt_valid) evt_bit[evt_slot] = 1'b1;
    end

    // Next done map: read clears first, the new completion is added after.
    always_comb done_next = (rd_done ? '0 : done_map) | evt_bit;

    cmpl_mask_eval #(.NUM_SLOT(NUM_SLOT)) i_eval (
        .done_map (done_next),
        .or_mask  (or_mask),
        .and_mask (and_mask),
        .or_hit   (or_hit),
        .and_hit  (and_hit)
    );

    // A category fires only on a completion that meets a rule.
    always_comb fire = evt_valid && (or_hit || and_hit);

    // Done map register.
    always_ff @(posedge clk) begin
        if (!rst_n) done_map <= '0;
        else        done_map <= done_next;
    end

    // Mask registers, loaded by software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            or_mask  <= '0;
            and_mask <= '0;
        end else begin
            if (wr_or)  or_mask  <= wdata;
            if (wr_and) and_mask <= wdata;
        end
    end

    // R2: a completed slot is present in the map after the edge.
    p_done_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |=> done_map[$past(evt_slot)]);

    // R3: a read with no coincident completion empties the map.
    p_done_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !evt_valid) |=> (done_map == '0));

    // R6: with no read and no completion the map holds.
    p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_done && !evt_valid) |=> $stable(done_map));
endmodule

// File: rtl/cmpl_irq_status.sv
// Module: central status register (write-one-to-clear), enable register
// and the level interrupt output. Assumes fire strobes are single-cycle
// requests. A set wins over a clear in the same cycle.
module cmpl_irq_status #(
    parameter int NUM_CAT = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CAT-1:0] fire,
    input  logic               wr_status,
    input  logic               wr_enable,
    input  logic [NUM_CAT-1:0] wdata,
    output logic [NUM_CAT-1:0] status,
    output logic [NUM_CAT-1:0] enable,
    output logic               irq
);
    logic [NUM_CAT-1:0] clr_bits;

    // Bits to clear this cycle from a status write.
    always_comb clr_bits = wr_status ? wdata : '0;

    // Status register: clear written ones, then merge new fires.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_bits) | fire;
    end

    // Enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)         enable <= '0;
        else if (wr_enable) enable <= wdata;
    end

    // Level interrupt from enabled pending bits.
    always_comb irq = |(status & enable);

    // R4: every fired category is pending after the edge.
    p_fire_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire != '0) |=> ((status & $past(fire)) == $past(fire)));

    // R7: written ones are cleared unless a fire coincided.
    p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_status |=> ((status & $past(wdata) & ~$past(fire)) == '0));

    // R6: nothing changes status without a fire or a write.
    p_status_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_status && (fire == '0)) |=> $stable(status));

    // R9: the line stays up while neither status nor enable is written.
    p_irq_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_status && !wr_enable) |=> irq);
endmodule

// File: rtl/cmpl_irq_hub.sv
// Module: top of the completion interrupt aggregator. It decodes the
// register port, builds one category unit per transfer category and feeds
// their fire strobes into the shared status block. Assumes NUM_SLOT equals
// the data width and NUM_CAT is at most 3.
module cmpl_irq_hub
    import cmpl_irq_pkg::*;
#(
    parameter int NUM_CAT  = CI_NUM_CAT,
    parameter int NUM_SLOT = CI_NUM_SLOT,
    localparam int SLOT_W  = $clog2(NUM_SLOT)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CAT-1:0]        evt_valid,
    input  logic [NUM_CAT*SLOT_W-1:0] evt_slot,
    input  logic                      reg_wr,
    input  logic                      reg_rd,
    input  logic [CI_ADDR_W-1:0]      reg_addr,
    input  logic [CI_DATA_W-1:0]      reg_wdata,
    output logic [CI_DATA_W-1:0]      reg_rdata,
    output logic                      irq
);
    logic [1:0]          addr_grp;
    logic [1:0]          addr_fld;
    logic [NUM_SLOT-1:0] done_m [NUM_CAT];
    logic [NUM_SLOT-1:0] or_m   [NUM_CAT];
    logic [NUM_SLOT-1:0] and_m  [NUM_CAT];
    logic [NUM_CAT-1:0]  fire;
    logic [NUM_CAT-1:0]  status;
    logic [NUM_CAT-1:0]  enable;
    logic                ctrl_sel;

    // Split the address into group and field.
    always_comb begin
        addr_grp = reg_addr[3:2];
        addr_fld = reg_addr[1:0];
        ctrl_sel = (addr_grp == GRP_CTRL);
    end

    for (genvar c = 0; c < NUM_CAT; c++) begin : g_cat
        localparam logic [1:0] CAT_ID = 2'(c);
        logic grp_hit;
        always_comb grp_hit = (addr_grp == CAT_ID);

        cmpl_cat_unit #(.NUM_SLOT(NUM_SLOT)) i_cat (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt_valid (evt_valid[c]),
            .evt_slot  (evt_slot[c*SLOT_W +: SLOT_W]),
            .wr_or     (reg_wr && grp_hit && (addr_fld == FLD_OR)),
            .wr_and    (reg_wr && grp_hit && (addr_fld == FLD_AND)),
            .rd_done   (reg_rd && grp_hit && (addr_fld == FLD_DONE)),
            .wdata     (reg_wdata[NUM_SLOT-1:0]),
            .done_map  (done_m[c]),
            .or_mask   (or_m[c]),
            .and_mask  (and_m[c]),
            .fire      (fire[c])
        );
    end

    cmpl_irq_status #(.NUM_CAT(NUM_CAT)) i_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .wr_status (reg_wr && ctrl_sel && (addr_fld == CTRL_STAT)),
        .wr_enable (reg_wr && ctrl_sel && (addr_fld == CTRL_ENA)),
        .wdata     (reg_wdata[NUM_CAT-1:0]),
        .status    (status),
        .enable    (enable),
        .irq       (irq)
    );

    // Read multiplexer; unmapped addresses return zero.
    always_comb begin
        reg_rdata = '0;
        if (ctrl_sel) begin
            if (addr_fld == CTRL_STAT)     reg_rdata[NUM_CAT-1:0] = status;
            else if (addr_fld == CTRL_ENA) reg_rdata[NUM_CAT-1:0] = enable;
        end else begin
            for (int c = 0; c < NUM_CAT; c++) begin
                if (addr_grp == 2'(c)) begin
                    case (addr_fld)
                        FLD_DONE: reg_rdata[NUM_SLOT-1:0] = done_m[c];
                        FLD_OR:   reg_rdata[NUM_SLOT-1:0] = or_m[c];
                        FLD_AND:  reg_rdata[NUM_SLOT-1:0] = and_m[c];
                        default:  reg_rdata = '0;
                    endcase
                end
            end
        end
    end

    // R8: with nothing enabled the line never rises.
    p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable == '0) |-> !irq);

    // R1: the cycle after reset, the line is low.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !irq);
endmodule

// File: tb/test_cmpl_irq_hub.sv
// Bench for cmpl_irq_hub: walks a vector table, then runs directed tests.
module test_cmpl_irq_hub;
    localparam int CLK_T = 20;
    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_EV = 2'd2, OP_IRQ = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  addr;
        logic [31:0] data;   // write data, or {cat[9:8], slot[4:0]} for events
        logic [31:0] exp;    // expected read data or irq level
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 30;
    localparam vec_t VECS [NVEC] = '{
        '{OP_WR,  4'd1,  32'h0000_0011, 32'h0,          8'd10}, // R10 or mask cat0
        '{OP_RD,  4'd1,  32'h0,         32'h0000_0011, 8'd10}, // R10 readback
        '{OP_WR,  4'd13, 32'h7,         32'h0,          8'd10}, // R10 enable all
        '{OP_EV,  4'd0,  32'h001,       32'h0,          8'd6},  // R6 slot1 not in mask
        '{OP_RD,  4'd12, 32'h0,         32'h0,          8'd6},  // R6 status unchanged
        '{OP_IRQ, 4'd0,  32'h0,         32'h0,          8'd6},
        '{OP_EV,  4'd0,  32'h004,       32'h0,          8'd4},  // R4 slot4 in mask
        '{OP_RD,  4'd12, 32'h0,         32'h1,          8'd4},
        '{OP_IRQ, 4'd0,  32'h0,         32'h1,          8'd8},  // R8
        '{OP_RD,  4'd0,  32'h0,         32'h0000_0012, 8'd2},  // R2 done map
        '{OP_RD,  4'd0,  32'h0,         32'h0,          8'd3},  // R3 cleared
        '{OP_WR,  4'd12, 32'h0,         32'h0,          8'd7},  // R7 zero write
        '{OP_RD,  4'd12, 32'h0,         32'h1,          8'd7},
        '{OP_WR,  4'd12, 32'h1,         32'h0,          8'd7},  // R7 clear
        '{OP_RD,  4'd12, 32'h0,         32'h0,          8'd7},
        '{OP_IRQ, 4'd0,  32'h0,         32'h0,          8'd9},  // R9 all cleared
        '{OP_WR,  4'd10, 32'h8000_0001, 32'h0,          8'd5},  // R5 and mask cat2
        '{OP_EV,  4'd0,  32'h200,       32'h0,          8'd5},  // cat2 slot0
        '{OP_RD,  4'd12, 32'h0,         32'h0,          8'd5},  // R5 partial
        '{OP_EV,  4'd0,  32'h21F,       32'h0,          8'd5},  // cat2 slot31
        '{OP_RD,  4'd12, 32'h0,         32'h4,          8'd5},  // R5 complete
        '{OP_IRQ, 4'd0,  32'h0,         32'h1,          8'd8},
        '{OP_WR,  4'd13, 32'h3,         32'h0,          8'd8},  // disable cat2
        '{OP_IRQ, 4'd0,  32'h0,         32'h0,          8'd8},  // R8 gated
        '{OP_WR,  4'd5,  32'hFFFF_FFFF, 32'h0,          8'd4},  // or mask cat1
        '{OP_EV,  4'd0,  32'h107,       32'h0,          8'd4},  // cat1 slot7
        '{OP_IRQ, 4'd0,  32'h0,         32'h1,          8'd4},
        '{OP_WR,  4'd12, 32'h2,         32'h0,          8'd9},
        '{OP_IRQ, 4'd0,  32'h0,         32'h0,          8'd9},  // R9 only disabled left
        '{OP_RD,  4'd13, 32'h0,         32'h3,          8'd10}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  evt_valid = '0;
    logic [14:0] evt_slot = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #(CLK_T/2) clk = ~clk;

    cmpl_irq_hub i_cmpl_irq_hub (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_slot(evt_slot),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string what, input int req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // All drivers change at the falling edge; each task ends on one.
    task automatic idle();
        reg_wr = 1'b0; reg_rd = 1'b0; evt_valid = '0;
    endtask

    task automatic do_wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); idle();
    endtask

    task automatic do_rd(input logic [3:0] a, input logic [31:0] e, input int req,
                         input string what);
        reg_rd = 1'b1; reg_addr = a;
        #1; check(what, req, reg_rdata, e);
        @(negedge clk); idle();
    endtask

    task automatic do_ev(input int cat, input logic [4:0] slot);
        evt_valid[cat] = 1'b1; evt_slot[cat*5 +: 5] = slot;
        @(negedge clk); idle();
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #(CLK_T * 150000);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state on every address and on the line.
        check("irq after reset", 1, {31'b0, irq}, 32'h0);
        for (int a = 0; a < 16; a++) do_rd(4'(a), 32'h0, 1, "reg after reset");

        // Table walk.
        for (int i = 0; i < NVEC; i++) begin
            case (VECS[i].op)
                OP_WR: do_wr(VECS[i].addr, VECS[i].data);
                OP_RD: do_rd(VECS[i].addr, VECS[i].exp, int'(VECS[i].req), "table read");
                OP_EV: do_ev(int'(VECS[i].data[9:8]), VECS[i].data[4:0]);
                default: check("table irq", int'(VECS[i].req), {31'b0, irq}, VECS[i].exp);
            endcase
        end

        // R3: read-clear coinciding with a completion keeps the completion.
        do_ev(0, 5'd2);
        reg_rd = 1'b1; reg_addr = 4'd0; evt_valid[0] = 1'b1; evt_slot[4:0] = 5'd9;
        #1; check("done read before clear", 3, reg_rdata, 32'h0000_0004);
        @(negedge clk); idle();
        do_rd(4'd0, 32'h0000_0200, 3, "completion kept over clear");

        // R7: status clear coinciding with a set of the same bit keeps it set.
        reg_wr = 1'b1; reg_addr = 4'd12; reg_wdata = 32'h1;
        evt_valid[0] = 1'b1; evt_slot[4:0] = 5'd0;
        @(negedge clk); idle();
        do_rd(4'd12, 32'h5, 7, "set wins over clear");

        // R9: level held until every enabled pending bit is cleared.
        do_wr(4'd13, 32'h7);
        check("irq two pending", 9, {31'b0, irq}, 32'h1);
        do_wr(4'd12, 32'h1);
        check("irq one pending left", 9, {31'b0, irq}, 32'h1);
        do_wr(4'd12, 32'h4);
        check("irq none pending", 9, {31'b0, irq}, 32'h0);

        // R5: zero AND mask with empty OR mask never triggers.
        do_wr(4'd5, 32'h0);
        do_ev(1, 5'd3);
        do_rd(4'd12, 32'h0, 5, "zero and mask no trigger");
        check("irq zero and mask", 5, {31'b0, irq}, 32'h0);

        // R2: done maps accumulate per category and slot.
        do_rd(4'd8, 32'h8000_0001, 2, "done map cat2");
        do_rd(4'd4, 32'h0000_0088, 2, "done map cat1");
        do_rd(4'd10, 32'h8000_0001, 10, "and mask readback");

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule